// File: doc/BRIEF.md
# Prime-Modulus Word Shift Register

This block holds sixteen 31-bit cells and advances them by one position on each step. The new top cell is a weighted sum of five cells, reduced modulo the prime 2^31−1. Each weight is a power of two, so each weighted term is a rotation of a cell within its 31 bits. The terms are summed by a tree of adders. Each adder folds its carry back into the low end of its sum.

A mode input selects between two ways of forming the feedback. In initialization mode, an external 31-bit word is added into the feedback. In working mode, that word is ignored. A zero result is replaced by the all-ones value, so a cell never takes the value zero through stepping.

The cells can be written all at once through a parallel load port, and all of them are visible on a flat output bus. Load takes priority over step. Each operation completes on one clock edge.

Top module: `mlfsr_top`

## Requirements
- R1: While `rst_n` is low, every cell is set to 0x7FFFFFFF (all ones), and it stays there until the first load or step after reset.
- R2: When `load_i` is high at a clock edge, cell i takes `load_data_i[31*i +: 31]` after that edge, whether or not `step_i` is also high.
- R3: When `step_i` is high and `load_i` is low, each cell i for i = 0..14 takes the old value of cell i+1 after the edge.
- R4: In working mode (`init_mode_i` low), the new cell 15 is the sum modulo 2^31−1 of s0, s0·2^8, s4·2^20, s10·2^21, s13·2^17 and s15·2^15, where sN is the old cell N.
- R5: In initialization mode (`init_mode_i` high), the new cell 15 is the R4 sum plus `feed_i`, modulo 2^31−1. In working mode, the value of `feed_i` has no effect on any cell.
- R6: If the reduced feedback is congruent to zero, the new cell 15 is 0x7FFFFFFF. This includes the case where every term is zero. Cell 15 is never 0 after a step.
- R7: The modular adder forms the 32-bit sum a+b and returns its low 31 bits plus its bit 31. So a+b = 2^31−1 gives 0x7FFFFFFF, and a+b = 2^31 gives 1.
- R8: When neither `load_i` nor `step_i` is high, no cell changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Parallel load strobe (has priority over step) |
| load_data_i | input | 496 | Values to load; cell i is bits [31*i +: 31] |
| step_i | input | 1 | Advance the register by one position |
| init_mode_i | input | 1 | 1 = initialization mode (add `feed_i`), 0 = working mode |
| feed_i | input | 31 | External word added to the feedback in initialization mode |
| cells_o | output | 496 | Current cells; cell i is bits [31*i +: 31] |

## Verification
The feedback is tried with three kinds of stimulus:
- random legal cell contents, which tell a wrong tap or rotation apart from a correct one;
- all-zero and all-ones cell banks, which exercise the zero replacement and the representation of zero as all ones;
- a bank whose feedback is cancelled exactly by `feed_i`, which separates a missing end-around carry from a correct reduction.

Working-mode steps with differing `feed_i` values show that the word is ignored, and initialization-mode steps show that it is added. The adder is also driven directly, at sums just below, equal to and above 2^31−1.

// File: rtl/mlfsr_pkg.sv
package mlfsr_pkg;
    parameter int CELL_W = 31;
    parameter int NCELLS = 16;
    localparam int BUS_W = CELL_W * NCELLS;

    typedef logic [CELL_W-1:0]             cell_t;
    typedef logic [NCELLS-1:0][CELL_W-1:0] bank_t;

    localparam cell_t CELL_ONES = '1;

    // multiplication by 2^k modulo 2^CELL_W-1 is a rotation inside the cell
    function automatic cell_t rotl(cell_t x, int k);
        return (x << k) | (x >> (CELL_W - k));
    endfunction
endpackage

// File: rtl/mersenne_add.sv
module mersenne_add #(
    parameter int W = 31
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        // end-around carry: the weight 2^W is congruent to 1
        sum = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end
endmodule

// File: rtl/mlfsr_feedback.sv
module mlfsr_feedback
    import mlfsr_pkg::*;
(
    input  bank_t bank,
    input  logic  add_ext,
    input  cell_t ext,
    output cell_t fb
);
    localparam int NTAPS  = 5;
    localparam int NTERMS = NTAPS + 2;
    localparam int NLEAF  = 1 << $clog2(NTERMS);
    localparam int NNODE  = 2 * NLEAF - 1;
    localparam int TAP_CELL [NTAPS] = '{15, 13, 10, 4, 0};
    localparam int TAP_ROT  [NTAPS] = '{15, 17, 21, 20, 8};

    cell_t node [NNODE];

    genvar t;
    generate
        for (t = 0; t < NLEAF; t++) begin : g_leaf
            if (t < NTAPS) begin : g_rot
                assign node[NLEAF-1+t] = rotl(bank[TAP_CELL[t]], TAP_ROT[t]);
            end else if (t == NTAPS) begin : g_plain
                assign node[NLEAF-1+t] = bank[0];
            end else if (t == NTAPS + 1) begin : g_ext
                assign node[NLEAF-1+t] = add_ext ? ext : '0;
            end else begin : g_pad
                assign node[NLEAF-1+t] = '0;
            end
        end

        for (t = 0; t < NLEAF - 1; t++) begin : g_tree
            mersenne_add #(.W(CELL_W)) u_add (
                .a   (node[2*t+1]),
                .b   (node[2*t+2]),
                .sum (node[t])
            );
        end
    endgenerate

    assign fb = (node[0] == '0) ? CELL_ONES : node[0];
endmodule

// File: rtl/mlfsr_top.sv
module mlfsr_top
    import mlfsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [BUS_W-1:0] load_data_i,
    input  logic             step_i,
    input  logic             init_mode_i,
    input  logic [CELL_W-1:0] feed_i,
    output logic [BUS_W-1:0] cells_o
);
    typedef struct packed {
        bank_t bank;
    } state_t;

    state_t state_d, state_q;
    cell_t  fb;

    mlfsr_feedback u_fb (
        .bank    (state_q.bank),
        .add_ext (init_mode_i),
        .ext     (feed_i),
        .fb      (fb)
    );

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.bank = bank_t'(load_data_i);
        end else if (step_i) begin
            state_d.bank = {fb, state_q.bank[NCELLS-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.bank <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign cells_o = state_q.bank;

    // R2
    load_takes_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (state_q.bank == bank_t'($past(load_data_i))));

    // R3
    shift_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (state_q.bank[NCELLS-2:0] == $past(state_q.bank[NCELLS-1:1])));

    // R6
    top_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (state_q.bank[NCELLS-1] != '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(state_q.bank));
endmodule

// File: tb/test_mlfsr_top.sv
`timescale 1ns/1ps
module test_mlfsr_top;
    import mlfsr_pkg::*;

    localparam longint P = (64'd1 << 31) - 1;

    logic             clk = 0;
    logic             rst_n = 0;
    logic             load_i = 0;
    logic [BUS_W-1:0] load_data_i = '0;
    logic             step_i = 0;
    logic             init_mode_i = 0;
    logic [CELL_W-1:0] feed_i = '0;
    logic [BUS_W-1:0] cells_o;

    cell_t add_a = '0, add_b = '0, add_s;

    mlfsr_top i_mlfsr_top (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_data_i(load_data_i),
        .step_i(step_i), .init_mode_i(init_mode_i), .feed_i(feed_i), .cells_o(cells_o)
    );

    mersenne_add #(.W(CELL_W)) i_add (.a(add_a), .b(add_b), .sum(add_s));

    always #2 clk = ~clk;

    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;
    bank_t mdl;

    typedef struct {
        int    due;
        bank_t exp;
        string tag;
    } item_t;
    item_t sb[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint mulpow(longint s, int k);
        return (s << k) % P;
    endfunction

    function automatic cell_t fb_model(bank_t b, bit im, longint u);
        longint t, r;
        t = longint'(b[0]) + mulpow(longint'(b[0]), 8) + mulpow(longint'(b[4]), 20)
          + mulpow(longint'(b[10]), 21) + mulpow(longint'(b[13]), 17)
          + mulpow(longint'(b[15]), 15) + (im ? u : 0);
        r = t % P;
        if (r == 0) r = P;
        return cell_t'(r);
    endfunction

    function automatic cell_t add_model(longint a, longint b);
        longint r;
        if (a + b == 0) return '0;
        r = (a + b) % P;
        if (r == 0) r = P;
        return cell_t'(r);
    endfunction

    task automatic do_op(bit ld, bank_t data, bit st, bit im, cell_t u, string tag);
        item_t it;
        @(negedge clk);
        load_i = ld; load_data_i = data; step_i = st; init_mode_i = im; feed_i = u;
        if (ld) mdl = data;
        else if (st) mdl = {fb_model(mdl, im, longint'(u)), mdl[NCELLS-1:1]};
        it.due = cyc + 1; it.exp = mdl; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            bank_t act;
            it = sb.pop_front();
            act = bank_t'(cells_o);
            checks++;
            if (act != it.exp) begin
                int bad;
                bad = 0;
                for (int i = NCELLS - 1; i >= 0; i--) if (act[i] != it.exp[i]) bad = i;
                errors++;
                $display("FAIL %s: cell %0d actual %h expected %h", it.tag, bad, act[bad], it.exp[bad]);
            end
        end
    end

    task automatic chk_add(cell_t a, cell_t b, string tag);
        cell_t e;
        add_a = a; add_b = b;
        #1;
        e = add_model(longint'(a), longint'(b));
        checks++;
        if (add_s != e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, add_s, e);
        end
    endtask

    function automatic bank_t rnd_bank();
        bank_t b;
        for (int i = 0; i < NCELLS; i++) begin
            b[i] = cell_t'($urandom);
            if (b[i] == '0) b[i] = 1;
        end
        return b;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bank_t b;
        cell_t c;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        @(negedge clk);
        checks++;
        if (cells_o != '1) begin
            errors++;
            $display("FAIL R1 reset: actual %h expected all ones", cells_o[CELL_W-1:0]);
        end
        mdl = '1;
        do_op(0, '0, 0, 0, '0, "R1 reset held");
        do_op(0, '0, 1, 0, '0, "R6 step from all ones");

        // R7 adder corners
        chk_add(31'h0000_0000, 31'h0000_0000, "R7 zero plus zero");
        chk_add(31'h4000_0000, 31'h3FFF_FFFF, "R7 sum equals modulus");
        chk_add(31'h4000_0000, 31'h4000_0000, "R7 sum modulus plus one");
        chk_add(31'h7FFF_FFFF, 31'h7FFF_FFFF, "R7 max plus max");
        chk_add(31'h0000_1234, 31'h0000_0001, "R7 small no carry");
        chk_add(31'h7FFF_FFFE, 31'h0000_0003, "R7 carry wrap");
        for (int i = 0; i < 20; i++) chk_add(cell_t'($urandom), cell_t'($urandom), "R7 random");

        // R2 load, R3/R4 work steps
        b = rnd_bank();
        do_op(1, b, 0, 0, '0, "R2 load");
        for (int i = 0; i < 6; i++) do_op(0, '0, 1, 0, cell_t'($urandom), "R3 R4 work step");
        // R5 feed ignored in working mode: two identical banks, different feed
        b = rnd_bank();
        do_op(1, b, 0, 0, '0, "R2 load");
        do_op(0, '0, 1, 0, 31'h0000_0000, "R5 work feed zero");
        do_op(1, b, 0, 0, '0, "R2 reload");
        do_op(0, '0, 1, 0, 31'h5A5A_1234, "R5 work feed ignored");
        // R5 init mode
        for (int i = 0; i < 8; i++) do_op(0, '0, 1, 1, cell_t'($urandom), "R5 init step");
        // R2 load beats step
        b = rnd_bank();
        do_op(1, b, 1, 1, 31'h1111_1111, "R2 load priority");
        // R8 idle
        do_op(0, '0, 0, 1, 31'h7777_7777, "R8 idle hold");
        // R6 all zero bank, feed zero
        do_op(1, '0, 0, 0, '0, "R2 load zeros");
        do_op(0, '0, 1, 1, '0, "R6 all terms zero");
        // R6 all ones bank (congruent zero)
        do_op(1, '1, 0, 0, '0, "R2 load ones");
        do_op(0, '0, 1, 0, '0, "R6 ones bank");
        // R6 feed cancels the feedback exactly
        b = rnd_bank();
        do_op(1, b, 0, 0, '0, "R2 load");
        c = fb_model(b, 0, 0);
        do_op(0, '0, 1, 1, cell_t'(P - longint'(c)), "R6 cancelled feedback");
        // mixed long run
        for (int i = 0; i < 150; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r == 0) do_op(1, rnd_bank(), $urandom_range(0, 1), 0, '0, "R2 random load");
            else if (r == 1) do_op(0, '0, 0, 0, cell_t'($urandom), "R8 random idle");
            else do_op(0, '0, 1, $urandom_range(0, 1), cell_t'($urandom), "R4 R5 random step");
        end
        do_op(0, '0, 0, 0, '0, "R8 final idle");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule